// File: doc/BRIEF.md
# Sticky Per-Channel Fault Status Capture

This block records LED channel faults for an eight-channel constant-current driver. Digital flags from comparators outside the block enter it: open load and shorted load for each channel, overtemperature for each channel, and one global overtemperature flag. A sticky register keeps one status bit per channel. The block also gates each channel's drive when a thermal flag is raised. The channel comes back by itself once the flag clears.

In special mode, the block samples the active-low output enable on every clock. It counts consecutive low samples and raises a load request for the shared shift register. The request tells that register to take the parallel status word in place of serial input. When the enable returns high, the request drops at once and the captured bits can be shifted out. Leaving special mode wipes every recorded fault.

Top module: `fault_status_capture`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, no fault is recorded and `load_req` is 0.
- R2: Bit i of `stat_word` is 1 exactly when channel i is requested on (`latch_on[i]`=1 and `oe_n`=0) and no fault is recorded for it. A channel that is not requested reads 0.
- R3: An open-load or shorted-load flag is recorded only if it is present at a clock edge where the channel is driven (`drv_en[i]`=1). A flag on a channel that is off leaves its bit unchanged.
- R4: A recorded fault stays recorded while `spec_mode` remains 1, even after the flag that caused it has gone away.
- R5: While `glob_ot` is 1, every bit of `drv_en` is 0. A clock edge in special mode with `glob_ot` high records a fault on every channel.
- R6: While `ch_ot[i]` is 1, only `drv_en[i]` is forced to 0. If channel i is requested on at that edge, only bit i is recorded as faulty.
- R7: Once the thermal flags clear, `drv_en[i]` returns to 1 without any other action as long as channel i is still requested on. Its status bit stays 0.
- R8: A clock edge with `spec_mode` low clears all recorded faults. No fault is recorded in normal mode.
- R9: `load_req` is 1 when `spec_mode`=1, `oe_n`=0, and the two previous clock edges both sampled `oe_n`=0 in special mode. It stays 1 on every later consecutive low sample.
- R10: `load_req` is 0 in the same cycle that `oe_n` is 1. A new run of low samples must again reach a count of two before the next request.
- R11: `load_req` is never 1 while `spec_mode` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| spec_mode | input | 1 | 1 = special (detection) mode, 0 = normal mode |
| oe_n | input | 1 | Active-low output enable, sampled each rising edge |
| latch_on | input | 8 | Output latch bit per channel, 1 = channel commanded on |
| open_flt | input | 8 | Open-load comparator flag per channel, 1 = fault |
| short_flt | input | 8 | Shorted-load comparator flag per channel, 1 = fault |
| ch_ot | input | 8 | Per-channel overtemperature flag, 1 = too hot |
| glob_ot | input | 1 | Global overtemperature flag, 1 = too hot |
| drv_en | output | 8 | Per-channel current sink enable after thermal gating |
| stat_word | output | 8 | Parallel status word, 1 = channel normal |
| load_req | output | 1 | Shift register should take `stat_word` on this edge |

## Verification
The bench drives an open-load flag on a channel that is off. A design that records faults without regard to drive would then show a 0 in that bit once the channel is switched on. Raising `oe_n` in the middle of a low run, with one or two lows only, catches a counter that fails to restart. It also catches a request that is issued one sample early. Removing each flag after it has been recorded catches a status register that is not sticky. A thermal flag followed by its release checks that the drive restarts while the fault bit stays 0. Dropping `spec_mode` checks that every bit is wiped and that detection is blocked in normal mode.

// File: rtl/fs_pkg.sv
package fs_pkg;

    typedef struct packed {
        logic on;
        logic open;
        logic shrt;
        logic ot;
    } chan_in_t;

    function automatic logic fault_seen(input chan_in_t c, input logic driven,
                                        input logic glob, input logic use_short);
        logic load_bad;
        load_bad = c.open | (use_short & c.shrt);
        return glob | (c.on & c.ot) | (driven & load_bad);
    endfunction

endpackage

// File: rtl/fs_chan_cell.sv
module fs_chan_cell
    import fs_pkg::*;
#(
    parameter bit SHORT_EN = 1'b1
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     clr,
    input  logic     glob_ot,
    input  chan_in_t cin,
    output logic     drv,
    output logic     stat
);
    logic flt_q;

    always_comb begin
        drv  = cin.on & ~glob_ot & ~cin.ot;
        stat = cin.on & ~flt_q;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            flt_q <= 1'b0;
        end else if (fault_seen(cin, drv, glob_ot, SHORT_EN)) begin
            flt_q <= 1'b1;
        end
    end

    a_r3_off_not_driven: assert property (@(posedge clk) disable iff (rst)
        !cin.on |-> !drv);
    a_r4_fault_sticky: assert property (@(posedge clk) disable iff (rst)
        (!clr && !stat && cin.on) |=> ($past(clr) || !cin.on || !stat || clr));
endmodule

// File: rtl/fs_low_counter.sv
module fs_low_counter #(
    parameter int LOAD_AFTER = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic spec_mode,
    input  logic oe_n,
    output logic load_req
);
    localparam int CNT_W = $clog2(LOAD_AFTER + 2);
    localparam logic [CNT_W-1:0] SAT = CNT_W'(LOAD_AFTER);

    logic [CNT_W-1:0] cnt_q;
    logic             low_now;

    always_comb begin
        low_now  = spec_mode & ~oe_n;
        load_req = low_now & (cnt_q == SAT);
    end

    always_ff @(posedge clk) begin
        if (rst || !low_now) begin
            cnt_q <= '0;
        end else if (cnt_q != SAT) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    a_r9_prior_low: assert property (@(posedge clk) disable iff (rst)
        load_req |-> ($past(spec_mode) && !$past(oe_n)));
    a_r10_high_blocks: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> !load_req);
    a_r11_normal_quiet: assert property (@(posedge clk) disable iff (rst)
        !spec_mode |-> !load_req);
endmodule

// File: rtl/fault_status_capture.sv
module fault_status_capture
    import fs_pkg::*;
#(
    parameter int N_CH       = 8,
    parameter bit SHORT_EN   = 1'b1,
    parameter int LOAD_AFTER = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            spec_mode,
    input  logic            oe_n,
    input  logic [N_CH-1:0] latch_on,
    input  logic [N_CH-1:0] open_flt,
    input  logic [N_CH-1:0] short_flt,
    input  logic [N_CH-1:0] ch_ot,
    input  logic            glob_ot,
    output logic [N_CH-1:0] drv_en,
    output logic [N_CH-1:0] stat_word,
    output logic            load_req
);
    logic [N_CH-1:0] req_on;

    assign req_on = latch_on & {N_CH{~oe_n}};

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        chan_in_t cin;
        always_comb begin
            cin.on   = req_on[i];
            cin.open = open_flt[i];
            cin.shrt = short_flt[i];
            cin.ot   = ch_ot[i];
        end
        fs_chan_cell #(.SHORT_EN(SHORT_EN)) u_cell (
            .clk     (clk),
            .rst     (rst),
            .clr     (~spec_mode),
            .glob_ot (glob_ot),
            .cin     (cin),
            .drv     (drv_en[i]),
            .stat    (stat_word[i])
        );
    end

    fs_low_counter #(.LOAD_AFTER(LOAD_AFTER)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .spec_mode (spec_mode),
        .oe_n      (oe_n),
        .load_req  (load_req)
    );

    a_r5_global_gate: assert property (@(posedge clk) disable iff (rst)
        glob_ot |-> (drv_en == '0));
    a_r5_global_clear: assert property (@(posedge clk) disable iff (rst)
        (spec_mode && glob_ot) |=> (!spec_mode || stat_word == '0));
    a_r8_normal_wipe: assert property (@(posedge clk) disable iff (rst)
        !spec_mode |=> (stat_word == (latch_on & {N_CH{~oe_n}})));
    a_r2_off_reads_zero: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> (stat_word == '0));
endmodule

// File: tb/sim_fault_status_capture.sv
module sim_fault_status_capture;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       spec_mode = 1'b0;
    logic       oe_n = 1'b1;
    logic [7:0] latch_on = '0, open_flt = '0, short_flt = '0, ch_ot = '0;
    logic       glob_ot = 1'b0;
    logic [7:0] drv_en, stat_word;
    logic       load_req;

    int  n_run = 0, n_bad = 0, cycles = 0;
    string cur_req = "R1";
    bit  done = 1'b0;

    logic [7:0] m_flt = '0;
    int         m_low = 0;

    always #5 clk = ~clk;

    fault_status_capture u0 (
        .clk(clk), .rst(rst), .spec_mode(spec_mode), .oe_n(oe_n),
        .latch_on(latch_on), .open_flt(open_flt), .short_flt(short_flt),
        .ch_ot(ch_ot), .glob_ot(glob_ot), .drv_en(drv_en),
        .stat_word(stat_word), .load_req(load_req));

    function automatic logic [7:0] m_on();
        return oe_n ? 8'h00 : latch_on;
    endfunction
    function automatic logic [7:0] m_drv();
        return glob_ot ? 8'h00 : (m_on() & ~ch_ot);
    endfunction

    always @(posedge clk) begin
        logic [7:0] drv_now;
        drv_now = m_drv();
        cycles++;
        if (rst || !spec_mode) begin
            m_flt = '0;
        end else begin
            if (glob_ot) m_flt = 8'hFF;
            m_flt = m_flt | (m_on() & ch_ot) | (drv_now & (open_flt | short_flt));
        end
        if (!rst && spec_mode && !oe_n) m_low = (m_low >= 2) ? 2 : m_low + 1;
        else m_low = 0;
    end

    always @(negedge clk) begin
        logic [7:0] e_stat, e_drv;
        logic       e_load;
        #2;
        if (!done) begin
            e_drv  = m_drv();
            e_stat = m_on() & ~m_flt;
            e_load = spec_mode && !oe_n && (m_low >= 2);
            n_run++;
            if (drv_en !== e_drv) begin
                n_bad++;
                $display("FAIL %s drv_en act=%h exp=%h t=%0t", cur_req, drv_en, e_drv, $time);
            end
            n_run++;
            if (stat_word !== e_stat) begin
                n_bad++;
                $display("FAIL %s stat_word act=%h exp=%h t=%0t", cur_req, stat_word, e_stat, $time);
            end
            n_run++;
            if (load_req !== e_load) begin
                n_bad++;
                $display("FAIL %s load_req act=%b exp=%b t=%0t", cur_req, load_req, e_load, $time);
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        cur_req = "R1";
        cyc(3);
        rst = 1'b0;
        cyc(2);
        cur_req = "R2";
        latch_on = 8'hA5; oe_n = 1'b0;
        cyc(3);
        cur_req = "R8";
        open_flt = 8'h01;
        cyc(3);
        open_flt = '0;
        spec_mode = 1'b1;
        cyc(2);
        cur_req = "R3";
        open_flt = 8'h06;
        cyc(2);
        open_flt = '0;
        latch_on = 8'hA7;
        cyc(2);
        short_flt = 8'h20;
        cyc(2);
        cur_req = "R4";
        short_flt = '0;
        cyc(3);
        cur_req = "R6";
        ch_ot = 8'h80;
        cyc(3);
        cur_req = "R7";
        ch_ot = '0;
        cyc(3);
        cur_req = "R5";
        glob_ot = 1'b1;
        cyc(3);
        glob_ot = 1'b0;
        cyc(2);
        cur_req = "R8";
        spec_mode = 1'b0;
        cyc(3);
        spec_mode = 1'b1;
        cyc(1);
        cur_req = "R10";
        oe_n = 1'b1; cyc(2);
        oe_n = 1'b0; cyc(1);
        oe_n = 1'b1; cyc(1);
        oe_n = 1'b0; cyc(2);
        oe_n = 1'b1; cyc(2);
        cur_req = "R9";
        oe_n = 1'b0; cyc(6);
        oe_n = 1'b1; cyc(2);
        cur_req = "R11";
        spec_mode = 1'b0;
        oe_n = 1'b0; cyc(6);
        open_flt = 8'hFF; cyc(2);
        open_flt = '0;
        cur_req = "R1";
        rst = 1'b1; spec_mode = 1'b1; cyc(2);
        rst = 1'b0; cyc(3);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

    initial begin
        wait (cycles > 20000);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_bad++;
            $display("FAIL %s watchdog expired act=%0d exp<=20000", cur_req, cycles);
            $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
            $finish;
        end
    end
endmodule